// File: doc/BRIEF.md
# Dual-Channel Sample Demultiplexer with Forwarded Data Clock

This block sits between the two converter cores (I and Q) of a dual high-speed ADC and the output pads. On each converter clock it takes one signed raw sample per channel. It turns each sample into an 8-bit offset-binary code and flags samples that fall outside the programmed full-scale window. It then places the codes on output buses together with a source-synchronous data clock.

In 1:2 demultiplexed mode, consecutive samples are paired. The earlier sample of each pair goes onto a lagging bus and the later one onto a direct bus, so both buses update once every two converter clocks. In non-demultiplexed mode, only the direct bus carries data, it updates on every converter clock, and the lagging buses are disabled. The data clock is registered. Every data update happens on an edge of the data clock (the rising edge in single-rate form, both edges in double-rate form). A second clock output carries an identical copy of the data clock.

During the termination-trim phase of a calibration, the data clock is parked low. A trim-disable input lets the clock keep running through every trim after the first one following reset. Configuration inputs are static while the block is out of reset.

Top module: `adc_demux_fmt`

## Requirements
- R1: With `demux_en`=1, `di_d`/`dq_d` carry the earlier and `di_u`/`dq_u` the later sample of each consecutive pair. Both buses update together every second converter clock. The first pair (the samples present at the first and second clock edges after reset release) appears after the third edge.
- R2: With `demux_en`=1 and `ddr_en`=0, `dclk` goes high on each edge that launches a pair and low on the following edge (period of 2 converter clocks).
- R3: With `demux_en`=1 and `ddr_en`=1, `dclk` toggles on each edge that launches a pair (period of 4 converter clocks).
- R4: With `demux_en`=0, `di_u`/`dq_u` take a new sample on every edge, with the sample at edge k shown after edge k+1. `dclk` toggles on every edge whatever `ddr_en` is. `di_d`/`dq_d` are 0 and `d_oe` is 0.
- R5: The raw input is two's complement. The output code is raw+128, clamped to 0 for raw below -128 and to 255 for raw above 127.
- R6: `ovr` is 1 when a sample satisfies raw > `fs_half` or raw < -`fs_half`, and it is aligned with the data it describes. In demux mode it covers both samples of the pair on both channels; in non-demux mode it covers the current I and Q samples.
- R7: While `cal_active` and `trim_phase` are both 1 and gating applies, `dclk` is low from the next edge on. It resumes its pattern afterwards.
- R8: With `trim_dis`=1, trim windows after the first completed one since reset do not gate `dclk`. The first trim window always gates.
- R9: `dclk2` equals `dclk` on every cycle.
- R10: During reset, all data outputs, `ovr`, `dclk` and `dclk2` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| demux_en | input | 1 | 1 = 1:2 demultiplexed, 0 = direct output |
| ddr_en | input | 1 | 1 = double-rate data clock in demux mode |
| trim_dis | input | 1 | Skip clock gating for trims after the first |
| cal_active | input | 1 | Calibration cycle in progress |
| trim_phase | input | 1 | Termination-trim portion of calibration |
| fs_half | input | IW-1 | Half full-scale limit, in raw units |
| i_raw | input | IW | I-channel signed raw sample |
| q_raw | input | IW | Q-channel signed raw sample |
| di_u | output | DW | I direct (later sample) bus |
| dq_u | output | DW | Q direct (later sample) bus |
| di_d | output | DW | I lagging (earlier sample) bus |
| dq_d | output | DW | Q lagging (earlier sample) bus |
| d_oe | output | 1 | Enable of the lagging buses |
| dclk | output | 1 | Forwarded data clock |
| dclk2 | output | 1 | Mirror of the data clock |
| ovr | output | 1 | Out-of-range flag |

## Verification
A wrong pair phase shows up at the first data clock rise after reset: the pair appears one converter clock late, or the two samples are swapped between the lagging and direct buses. The bench compares every output on every cycle, so such a fault is reported within three clocks of reset release. A wrong trim-done state is visible only during a later calibration, where the clock either stops when it should run or keeps running when it should stop. The bench therefore runs two calibrations after each reset. A misaligned range flag shows on the first boundary sample, and the bench drives these samples often.

// File: rtl/adc_demux_fmt.sv
module adc_demux_fmt #(
  parameter int DW = 8,
  parameter int IW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 demux_en,
  input  logic                 ddr_en,
  input  logic                 trim_dis,
  input  logic                 cal_active,
  input  logic                 trim_phase,
  input  logic [IW-2:0]        fs_half,
  input  logic signed [IW-1:0] i_raw,
  input  logic signed [IW-1:0] q_raw,
  output logic [DW-1:0]        di_u,
  output logic [DW-1:0]        dq_u,
  output logic [DW-1:0]        di_d,
  output logic [DW-1:0]        dq_d,
  output logic                 d_oe,
  output logic                 dclk,
  output logic                 dclk2,
  output logic                 ovr
);
  localparam int HI = 2**(DW-1) - 1;
  localparam int LO = -(2**(DW-1));
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] to_code(input logic signed [IW-1:0] r);
    if (int'(r) > HI) return '1;
    else if (int'(r) < LO) return '0;
    else return r[DW-1:0] ^ MID;
  endfunction

  function automatic logic out_rng(input logic signed [IW-1:0] r, input logic [IW-2:0] lim);
    logic signed [IW:0] rx, lx;
    rx = {r[IW-1], r};
    lx = {2'b00, lim};
    return (rx > lx) || (rx < -lx);
  endfunction

  logic          v, ph, seen, first_done;
  logic [DW-1:0] s_i, s_q, h_i, h_q;
  logic          s_or, h_or;
  logic          win, gate, launch, dclk_nxt;

  assign win    = cal_active & trim_phase;
  assign gate   = win & (~trim_dis | ~first_done);
  assign launch = v & (demux_en ? ph : 1'b1);
  assign d_oe   = demux_en;

  always_comb begin
    if (gate)          dclk_nxt = 1'b0;
    else if (!demux_en) dclk_nxt = dclk ^ v;
    else if (ddr_en)   dclk_nxt = dclk ^ (v & ph);
    else               dclk_nxt = v & ph;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= 1'b0; ph <= 1'b0; seen <= 1'b0; first_done <= 1'b0;
      s_i <= '0; s_q <= '0; s_or <= 1'b0;
      h_i <= '0; h_q <= '0; h_or <= 1'b0;
    end else begin
      v    <= 1'b1;
      seen <= seen | win;
      first_done <= first_done | (seen & ~win);
      s_i  <= to_code(i_raw);
      s_q  <= to_code(q_raw);
      s_or <= out_rng(i_raw, fs_half) | out_rng(q_raw, fs_half);
      if (v && demux_en) ph <= ~ph;
      if (v && demux_en && !ph) begin
        h_i <= s_i; h_q <= s_q; h_or <= s_or;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      di_u <= '0; dq_u <= '0; di_d <= '0; dq_d <= '0; ovr <= 1'b0;
    end else if (launch) begin
      di_u <= s_i;
      dq_u <= s_q;
      di_d <= demux_en ? h_i : '0;
      dq_d <= demux_en ? h_q : '0;
      ovr  <= s_or | (demux_en & h_or);
    end else if (!demux_en) begin
      di_d <= '0; dq_d <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk <= 1'b0; dclk2 <= 1'b0;
    end else begin
      dclk <= dclk_nxt; dclk2 <= dclk_nxt;
    end
  end

  // R1
  pair_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    demux_en && v && ph |=> di_d == $past(h_i) && dq_d == $past(h_q));
  // R4
  direct_lag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !demux_en |=> di_d == '0 && dq_d == '0 && !d_oe);
  // R4
  direct_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !demux_en && v && !win |=> dclk != $past(dclk));
  // R7
  trim_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win && !(trim_dis && first_done) |=> !dclk);
  // R9
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n) dclk2 == dclk);
endmodule

// File: tb/sim_adc_demux_fmt.sv
module sim_adc_demux_fmt;
  localparam int DW = 8, IW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic demux_en = 0, ddr_en = 0, trim_dis = 0, cal_active = 0, trim_phase = 0;
  logic [IW-2:0] fs_half = 9'd100;
  logic signed [IW-1:0] i_raw = '0, q_raw = '0;
  logic [DW-1:0] di_u, dq_u, di_d, dq_d;
  logic d_oe, dclk, dclk2, ovr;
  int nchk = 0, nerr = 0, rises = 0;
  logic prev = 0, p_cal = 0, p_trim = 0, done = 0;

  always #10 clk = ~clk;

  adc_demux_fmt #(.DW(DW), .IW(IW)) u0 (.*);

  function automatic int code(input int r);
    if (r > 127) return 255;
    if (r < -128) return 0;
    return r + 128;
  endfunction
  function automatic bit oor(input int r, input int f);
    return (r > f) || (r < -f);
  endfunction

  // reference model, built from R1..R10
  int c_i, c_q, hp_i, hp_q, e_iu, e_qu, e_id, e_qd;
  bit c_o, hp_o, e_or, e_clk, live, odd, trim_seen, trim_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_i = 0; c_q = 0; hp_i = 0; hp_q = 0; e_iu = 0; e_qu = 0; e_id = 0; e_qd = 0;
      c_o = 0; hp_o = 0; e_or = 0; e_clk = 0; live = 0; odd = 0; trim_seen = 0; trim_done = 0;
    end else begin
      bit w, g, go;
      w = cal_active && trim_phase;
      g = w && !(trim_dis && trim_done);
      go = live && (!demux_en || odd);
      if (g) e_clk = 0;
      else if (!demux_en) e_clk = live ? !e_clk : e_clk;
      else if (ddr_en) e_clk = go ? !e_clk : e_clk;
      else e_clk = go;
      if (go) begin
        e_iu = c_i; e_qu = c_q;
        e_id = demux_en ? hp_i : 0; e_qd = demux_en ? hp_q : 0;
        e_or = c_o || (demux_en && hp_o);
      end
      if (!demux_en) begin e_id = 0; e_qd = 0; end
      if (live && demux_en && !odd) begin hp_i = c_i; hp_q = c_q; hp_o = c_o; end
      if (live && demux_en) odd = !odd;
      trim_done = trim_done || (trim_seen && !w);
      trim_seen = trim_seen || w;
      c_i = code(int'(i_raw)); c_q = code(int'(q_raw));
      c_o = oor(int'(i_raw), int'(fs_half)) || oor(int'(q_raw), int'(fs_half));
      live = 1;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick_raw();
    int f = int'(fs_half);
    case ($urandom % 8)
      4: return f;
      5: return -f;
      6: return f + 1;
      7: case ($urandom % 4) 0: return 127; 1: return 128; 2: return -128; default: return -129; endcase
      default: return int'($urandom % 1024) - 512;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    chk(demux_en ? "R1" : "R4", "di_u", di_u, e_iu);
    chk(demux_en ? "R1" : "R4", "dq_u", dq_u, e_qu);
    chk(demux_en ? "R1" : "R4", "di_d", di_d, e_id);
    chk(demux_en ? "R1" : "R4", "dq_d", dq_d, e_qd);
    chk("R4", "d_oe", d_oe, demux_en);
    chk("R6", "ovr", ovr, e_or);
    chk(!demux_en ? "R4" : (ddr_en ? "R3" : "R2"), "dclk", dclk, e_clk);
    chk("R9", "dclk2", dclk2, dclk);
    if (dclk && !prev) rises++;
    prev = dclk;
    i_raw = IW'(pick_raw());
    q_raw = IW'(pick_raw());
    cal_active = p_cal;
    trim_phase = p_trim;
  endtask

  task automatic cal_seq(input bit later);
    int r0;
    p_cal = 1;
    for (int c = 0; c < 16; c++) begin
      p_trim = (c >= 4 && c < 10);
      if (c == 5) r0 = rises;
      step();
      if (c >= 6 && c <= 9 && !(later && trim_dis)) chk(later ? "R7" : "R8", "dclk parked", dclk, 0);
    end
    if (later && trim_dis) chk("R8", "dclk runs in later trim", int'(rises > r0), 1);
    p_cal = 0; p_trim = 0;
  endtask

  task automatic run_cfg(input bit dm, input bit dd, input bit td);
    int first;
    rst_n = 0; demux_en = dm; ddr_en = dd; trim_dis = td;
    p_cal = 0; p_trim = 0; cal_active = 0; trim_phase = 0;
    fs_half = 9'(40 + $urandom % 260);
    repeat (3) @(negedge clk);
    chk("R10", "reset dclk", dclk, 0);
    chk("R10", "reset dclk2", dclk2, 0);
    chk("R10", "reset ovr", ovr, 0);
    chk("R10", "reset di_u", di_u, 0);
    chk("R10", "reset dq_d", dq_d, 0);
    prev = 0;
    rst_n = 1;
    first = -1;
    for (int c = 1; c <= 6; c++) begin
      step();
      if (dclk && first < 0) first = c;
    end
    chk(dm ? "R1" : "R4", "first data clock rise", first, dm ? 3 : 2);
    repeat (4) step();
    rises = 0;
    repeat (40) step();
    chk(!dm ? "R4" : (dd ? "R3" : "R2"), "rises per 40 clocks", rises, (dm && dd) ? 10 : 20);
    i_raw = 10'sd200; q_raw = -10'sd300;
    step();
    step();
    if (!dm) begin
      chk("R5", "clamp high", di_u, 255);
      chk("R5", "clamp low", dq_u, 0);
    end
    cal_seq(0);
    repeat (20) step();
    cal_seq(1);
    for (int c = 0; c < 150; c++) begin
      if ($urandom % 12 == 0) p_cal = !p_cal;
      p_trim = p_cal && ($urandom % 3 == 0);
      step();
    end
    p_cal = 0; p_trim = 0;
    repeat (4) step();
  endtask

  initial begin
    void'($urandom(1234));
    run_cfg(0, 0, 0);
    run_cfg(0, 1, 1);
    run_cfg(1, 0, 0);
    run_cfg(1, 0, 1);
    run_cfg(1, 1, 0);
    run_cfg(1, 1, 1);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule